// File: doc/BRIEF.md
# Dual External Event Down-Counter

This block holds two independent down-counters, each of which counts rising edges on its own asynchronous event pin. Software loads a channel with a start value through a small register write port. Every rising edge seen on that channel's pin then takes one off the count. When the count reaches zero, the channel stops and raises a sticky interrupt request. Software can read the live count of either channel through a read port. It acknowledges an interrupt with a write-one-to-clear bit.

Each event pin is first resynchronised into the system clock domain, and a rising-edge detector follows. A pulse of any length therefore counts exactly once. The count width, the channel count and the synchroniser depth are parameters. The defaults are two channels of 16 bits with a two-flop synchroniser.

Top module: `dual_event_counter`

## Requirements
- R1: After reset, every channel reads a count of 0 and every interrupt output is low.
- R2: A rising edge on `ev_in[i]` is counted once, however many cycles the pin stays high. With the default two-stage synchroniser, the count changes on the third rising clock edge after the pin rises.
- R3: Each detected edge lowers only its own channel's count by exactly one. The other channel is unaffected.
- R4: The decrement that takes a count from 1 to 0 sets that channel's `irq[i]`. The flag is visible from the following cycle.
- R5: A channel at zero holds zero, and further edges on its pin have no effect until a new load.
- R6: `irq[i]` stays high until a write with `wr_en=1`, `wr_sel=i`, `wr_clr=1` and `wr_load=0` clears it. A write with `wr_clr=0` leaves it set.
- R7: A write with `wr_en=1` and `wr_load=1` stores `wr_data` into channel `wr_sel` and clears its interrupt. If an edge falls in the same cycle as the load, the load takes priority and that edge is lost.
- R8: Loading the value 0 sets the channel's interrupt on the next cycle and leaves the count at 0.
- R9: `rd_count` shows, in the same cycle, the count of the channel selected by `rd_sel`.
- R10: When a clear of a channel's interrupt and that channel's terminal decrement fall in the same cycle, the interrupt ends up set.
- R11: Loading the all-ones value 16'hFFFF is accepted, and the first edge afterwards gives 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Channel addressed by the write |
| wr_load | input | 1 | Write loads `wr_data` into the channel |
| wr_clr | input | 1 | Write-one-to-clear of the channel interrupt |
| wr_data | input | 16 | Load value |
| rd_sel | input | 1 | Channel shown on `rd_count` |
| rd_count | output | 16 | Current count of the selected channel |
| ev_in | input | 2 | Asynchronous event pins, one per channel |
| irq | output | 2 | Sticky interrupt requests, one per channel |

## Verification
Two functions can land in the same cycle. The first pair is a software clear of a channel's interrupt and the hardware decrement that sets it. The bench loads 1, raises the pin and issues the clear exactly two clock edges later, so the clear arrives in the cycle that holds the detected edge. It then expects the flag to be high. The second pair is a load and a detected edge. The bench times the load to meet the detected edge the same way and expects the freshly loaded value to be intact. Around both cases, sweeps over small load values and edge counts compare the count and flag against arithmetic computed in the bench.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

   // Per-channel command decoded from the register write port
   typedef struct packed {
      logic load;
      logic clr;
   } chan_cmd_t;

   // Width of an index able to address n items (at least one bit)
   function automatic int idx_width(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/evcnt_edge_sync.sv
module evcnt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("evcnt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   // Synchroniser chain: bit 0 samples the pin, the top bit is safe to use
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
      end
   end

   // Delayed copy of the synchronised level for rising-edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= chain_q[STAGES-1];
      end
   end

   assign pulse_o = chain_q[STAGES-1] & ~prev_q;

   // R2: a single rising edge yields a one-cycle pulse only
   a_r2_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/evcnt_channel.sv
module evcnt_channel
   import evcnt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_cmd_t        cmd,
   input  logic [CNT_W-1:0] load_val,
   input  logic             event_pulse,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("evcnt_channel: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] count_q, count_d;
   logic             irq_q, irq_d;
   logic             running;
   logic             terminal;

   assign running  = (count_q != ZERO);
   assign terminal = event_pulse && (count_q == ONE);

   always_comb begin
      count_d = count_q;
      irq_d   = irq_q;
      if (cmd.load) begin
         // Load wins over any same-cycle edge and over clear
         count_d = load_val;
         irq_d   = (load_val == ZERO);
      end else begin
         if (cmd.clr) irq_d = 1'b0;
         if (event_pulse && running) count_d = count_q - ONE;
         // Setting comes after clearing so a terminal count is never lost
         if (terminal) irq_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= ZERO;
         irq_q   <= 1'b0;
      end else begin
         count_q <= count_d;
         irq_q   <= irq_d;
      end
   end

   assign count_o = count_q;
   assign irq_o   = irq_q;

   // R3: an accepted edge lowers the count by exactly one
   a_r3_step_one : assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.load && event_pulse && count_o != ZERO) |=> (count_o == $past(count_o) - ONE));

   // R3: without an edge or a load the count does not move
   a_r3_idle_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.load && !event_pulse) |=> $stable(count_o));

   // R4 and R10: reaching zero raises the request, even under a clear
   a_r4_irq_at_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.load && event_pulse && count_o == ONE) |=> (irq_o && count_o == ZERO));

   // R5: a stopped channel stays at zero until reloaded
   a_r5_hold_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.load && count_o == ZERO) |=> (count_o == ZERO));

   // R6: the request is sticky without a clear or load
   a_r6_irq_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !cmd.clr && !cmd.load) |=> irq_o);

   // R7: a load stores the value regardless of a same-cycle edge
   a_r7_load_value : assert property (@(posedge clk) disable iff (!rst_n)
      cmd.load |=> (count_o == $past(load_val)));

   // R8: loading zero raises the request at once
   a_r8_load_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.load && load_val == ZERO) |=> irq_o);

endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
   import evcnt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = idx_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_load,
   input  logic              wr_clr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [CNT_W-1:0]  rd_count,
   input  logic [NUM_CH-1:0] ev_in,
   output logic [NUM_CH-1:0] irq
);

   if (NUM_CH < 1) begin : g_bad_channels
      $error("dual_event_counter: NUM_CH must be at least 1");
   end

   logic [CNT_W-1:0]  count_arr [NUM_CH];
   logic [NUM_CH-1:0] edge_pulse;
   chan_cmd_t         cmd_arr   [NUM_CH];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic hit;
      assign hit             = wr_en && (wr_sel == SEL_W'(ch));
      assign cmd_arr[ch].load = hit && wr_load;
      assign cmd_arr[ch].clr  = hit && wr_clr;

      evcnt_edge_sync #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (ev_in[ch]),
         .pulse_o  (edge_pulse[ch])
      );

      evcnt_channel #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .cmd         (cmd_arr[ch]),
         .load_val    (wr_data),
         .event_pulse (edge_pulse[ch]),
         .count_o     (count_arr[ch]),
         .irq_o       (irq[ch])
      );
   end

   // Read-back multiplexer; an unused index reads zero
   always_comb begin
      rd_count = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (rd_sel == SEL_W'(ch)) rd_count = count_arr[ch];
      end
   end

   // R1: out of reset no channel requests service
   a_r1_reset_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq == '0));

   // R6: a request cannot appear without a write or an edge
   a_r6_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && edge_pulse == '0) |=> ((irq & ~$past(irq)) == '0));

endmodule

// File: tb/tb_dual_event_counter.sv
module tb_dual_event_counter;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [0:0]    wr_sel = '0;
   logic          wr_load = 1'b0;
   logic          wr_clr = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic [0:0]    rd_sel = '0;
   logic [W-1:0]  rd_count;
   logic [1:0]    ev_in = '0;
   logic [1:0]    irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int exp_cnt [2];
   bit exp_irq [2];

   always #5 clk = ~clk;

   dual_event_counter dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_load  (wr_load),
      .wr_clr   (wr_clr),
      .wr_data  (wr_data),
      .rd_sel   (rd_sel),
      .rd_count (rd_count),
      .ev_in    (ev_in),
      .irq      (irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic read_ch(input int ch, output int val);
      rd_sel = 1'(ch);
      #1;
      val = int'(rd_count);
   endtask

   task automatic verify(input string req, input int ch);
      int v;
      read_ch(ch, v);
      chk(req, v, exp_cnt[ch]);
      chk(req, int'(irq[ch]), int'(exp_irq[ch]));
   endtask

   task automatic write_op(input int ch, input bit ld, input bit cl, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'(ch); wr_load = ld; wr_clr = cl; wr_data = W'(data);
      @(negedge clk);
      wr_en = 1'b0; wr_load = 1'b0; wr_clr = 1'b0;
      if (ld) begin
         exp_cnt[ch] = data;
         exp_irq[ch] = (data == 0);
      end else if (cl) begin
         exp_irq[ch] = 1'b0;
      end
   endtask

   // Raise the pin for 'high' cycles, drop it, wait for the count to settle
   task automatic pulse(input int ch, input int high);
      @(negedge clk);
      ev_in[ch] = 1'b1;
      repeat (high) @(negedge clk);
      ev_in[ch] = 1'b0;
      repeat (4) @(negedge clk);
      if (exp_cnt[ch] != 0) begin
         exp_cnt[ch]--;
         if (exp_cnt[ch] == 0) exp_irq[ch] = 1'b1;
      end
   endtask

   initial begin
      int v;
      exp_cnt[0] = 0; exp_cnt[1] = 0;
      exp_irq[0] = 0; exp_irq[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      verify("R1", 0);
      verify("R1", 1);

      // R8: load zero raises the request at once
      write_op(0, 1'b1, 1'b0, 0);
      verify("R8", 0);

      // R6: a write without the clear bit leaves the flag set
      write_op(0, 1'b0, 1'b0, 0);
      verify("R6", 0);
      write_op(0, 1'b0, 1'b1, 0);
      verify("R6", 0);

      // R2: exact latency - changes on the third edge, not before
      write_op(1, 1'b1, 1'b0, 10);
      @(negedge clk);
      ev_in[1] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      read_ch(1, v);
      chk("R2", v, 10);
      @(negedge clk);
      read_ch(1, v);
      chk("R2", v, 9);
      repeat (20) @(negedge clk);
      read_ch(1, v);
      chk("R2", v, 9);
      ev_in[1] = 1'b0;
      repeat (4) @(negedge clk);
      exp_cnt[1] = 9;
      verify("R2", 1);

      // R3 R4 R5 R7: sweep of load values and edge counts on channel 0,
      // with channel 1 checked untouched
      for (int val = 1; val <= 6; val++) begin
         for (int k = 0; k <= val + 1; k++) begin
            write_op(0, 1'b1, 1'b0, val);
            verify("R7", 0);
            for (int e = 0; e < k; e++) pulse(0, 1 + (e % 3));
            read_ch(0, v);
            chk("R3", v, (val > k) ? val - k : 0);
            chk("R4", int'(irq[0]), (k >= val) ? 1 : 0);
            verify("R3", 1);
         end
      end

      // R5: extra edges at zero are ignored
      write_op(1, 1'b1, 1'b0, 1);
      pulse(1, 2);
      pulse(1, 1);
      pulse(1, 3);
      verify("R5", 1);
      chk("R5", exp_cnt[1], 0);

      // R9: read mux selects each channel
      write_op(0, 1'b1, 1'b0, 16'h1234);
      write_op(1, 1'b1, 1'b0, 16'h00A5);
      read_ch(0, v); chk("R9", v, 16'h1234);
      read_ch(1, v); chk("R9", v, 16'h00A5);

      // R11: full-scale load
      write_op(1, 1'b1, 1'b0, 16'hFFFF);
      verify("R11", 1);
      pulse(1, 1);
      verify("R11", 1);
      chk("R11", exp_cnt[1], 16'hFFFE);

      // R10: clear lands in the cycle of the terminal decrement
      write_op(0, 1'b1, 1'b0, 1);
      @(negedge clk);
      ev_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_clr = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_clr = 1'b0;
      ev_in[0] = 1'b0;
      repeat (3) @(negedge clk);
      read_ch(0, v);
      chk("R10", v, 0);
      chk("R10", int'(irq[0]), 1);
      exp_cnt[0] = 0; exp_irq[0] = 1'b1;

      // R7: load meets a detected edge in the same cycle; edge is dropped
      @(negedge clk);
      ev_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_load = 1'b1; wr_data = W'(5);
      @(negedge clk);
      wr_en = 1'b0; wr_load = 1'b0;
      ev_in[0] = 1'b0;
      repeat (3) @(negedge clk);
      read_ch(0, v);
      chk("R7", v, 5);
      chk("R7", int'(irq[0]), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule